// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Group

This block holds a small pool of reservation stations placed in front of a single floating-point functional unit. An issue port takes one operation per cycle, with its opcode, destination register id and two source operands. Each source arrives either as a ready value (tag 0) or as the tag of the unit that will produce it. The lowest-indexed free station takes the operation, and the block reports that station's tag so the rename logic upstream can record it in place of the destination register. When every station is occupied the issue port stalls.

Stations with an outstanding operand watch a shared result bus carrying a 4-bit producer tag and 64 bits of data. When the tag matches, they latch the data. Every waiting station latches in the same cycle, including a station that is being issued in that cycle. A station whose two operands both hold values is eligible to start. The lowest-indexed eligible station goes to the functional unit, one per cycle, and each station is sent only once. The station stays allocated until the result bus carries its own tag. The functional unit, register file and instruction queue are outside the block.

Top module: `rs_group`

## Requirements
- R1: `issue_ready_o` is high exactly when at least one station is free. An operation is taken only when `issue_valid_i` and `issue_ready_o` are both high at a clock edge. It goes into the lowest-indexed free station, whose tag (station index plus one, so 1 to 3) is shown on `issue_tag_o`.
- R2: A source tag of 0 means the accompanying value is valid and is stored as given. A nonzero source tag leaves that operand waiting on the named producer.
- R3: A station is dispatched only while both of its operands hold values. Each issued operation is dispatched exactly once.
- R4: While the bus is valid and its tag equals a waiting operand's producer tag, that operand takes the bus data at the clock edge. This happens in the same cycle for every station waiting on that tag.
- R5: If an operand's producer tag appears on the bus in the same cycle that the operation is issued, the station stores the bus data and treats that operand as ready.
- R6: A dispatched station is freed at the edge where the bus is valid with that station's own tag. `issue_ready_o` reflects the freed station in the next cycle.
- R7: When several stations are eligible, the lowest-indexed one is dispatched, with at most one dispatch per cycle. `disp_valid_o` rises in the cycle after the station's last operand becomes valid.
- R8: After reset no station is busy: `disp_valid_o` is low and `issue_ready_o` is high.
- R9: A dispatch presents the stored opcode, destination id, both operand values and the station's tag.
- R10: A bus transfer whose tag differs from a waiting operand's producer tag leaves that operand waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Operation offered for issue |
| issue_ready_o | output | 1 | A station is free |
| issue_op_i | input | OP_W | Opcode |
| issue_dst_i | input | DST_W | Destination register id |
| issue_a_tag_i | input | 4 | Producer tag of source A, 0 = value valid |
| issue_a_val_i | input | 64 | Value of source A |
| issue_b_tag_i | input | 4 | Producer tag of source B, 0 = value valid |
| issue_b_val_i | input | 64 | Value of source B |
| issue_tag_o | output | 4 | Tag of the station the next issue takes |
| cdb_valid_i | input | 1 | Result bus carries a result |
| cdb_tag_i | input | 4 | Tag of the producing unit |
| cdb_data_i | input | 64 | Result value |
| disp_valid_o | output | 1 | Operation sent to the functional unit |
| disp_op_o | output | OP_W | Dispatched opcode |
| disp_dst_o | output | DST_W | Dispatched destination id |
| disp_a_o | output | 64 | Operand A value |
| disp_b_o | output | 64 | Operand B value |
| disp_tag_o | output | 4 | Tag of the dispatched station |

## Verification
The bench fills every station with operations waiting on one external tag. It then probes a full pool with further issue attempts; a design that ignored the stall would overwrite a station, and the lost or duplicated dispatch would be detected. A broadcast on an unrelated tag must release nothing, and a single matching broadcast must wake all three stations, which then dispatch in index order on consecutive cycles. A design with a wrong comparison or a wrong priority would send them out early or in a different order. Two further cases are a result that arrives in the same cycle as the issue of its consumer, which a design without the bypass would leave waiting forever, and a station that is reused after it is freed, which a design that freed stations at dispatch or never freed them would reuse at the wrong time or hang.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_TAG_W  = 4;
  localparam int unsigned RS_DATA_W = 64;

  typedef logic [RS_TAG_W-1:0]  tag_t;
  typedef logic [RS_DATA_W-1:0] data_t;

  // tag == 0 means val is valid
  typedef struct packed {
    tag_t  tag;
    data_t val;
  } operand_t;

  function automatic operand_t snoop(operand_t o, logic bus_v, tag_t bus_tag, data_t bus_data);
    operand_t r;
    r = o;
    if (bus_v && (o.tag != '0) && (o.tag == bus_tag)) begin
      r.tag = '0;
      r.val = bus_data;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_lowest_pick.sv
module rs_lowest_pick #(
  parameter int unsigned N     = 3,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int unsigned OP_W   = 4,
  parameter int unsigned DST_W  = 5,
  parameter tag_t        MY_TAG = tag_t'(1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [DST_W-1:0] dst_i,
  input  operand_t         a_i,
  input  operand_t         b_i,
  input  logic             cdb_valid_i,
  input  tag_t             cdb_tag_i,
  input  data_t            cdb_data_i,
  input  logic             fire_i,
  output logic             busy_o,
  output logic             ready_o,
  output logic [OP_W-1:0]  op_o,
  output logic [DST_W-1:0] dst_o,
  output data_t            a_o,
  output data_t            b_o
);
  logic             busy_q, started_q;
  logic [OP_W-1:0]  op_q;
  logic [DST_W-1:0] dst_q;
  operand_t         a_q, b_q;
  logic             own_result;

  assign own_result = cdb_valid_i && (cdb_tag_i == MY_TAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      started_q <= 1'b0;
      op_q      <= '0;
      dst_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
    end else if (alloc_i) begin
      busy_q    <= 1'b1;
      started_q <= 1'b0;
      op_q      <= op_i;
      dst_q     <= dst_i;
      a_q       <= snoop(a_i, cdb_valid_i, cdb_tag_i, cdb_data_i);
      b_q       <= snoop(b_i, cdb_valid_i, cdb_tag_i, cdb_data_i);
    end else begin
      a_q <= snoop(a_q, cdb_valid_i, cdb_tag_i, cdb_data_i);
      b_q <= snoop(b_q, cdb_valid_i, cdb_tag_i, cdb_data_i);
      if (fire_i) started_q <= 1'b1;
      if (busy_q && started_q && own_result) busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !started_q && (a_q.tag == '0) && (b_q.tag == '0);
  assign op_o    = op_q;
  assign dst_o   = dst_q;
  assign a_o     = a_q.val;
  assign b_o     = b_q.val;

  p_alloc_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_q);

  p_fire_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> (busy_q && !started_q && a_q.tag == '0 && b_q.tag == '0));

  p_capture_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && a_q.tag != '0 && cdb_valid_i && cdb_tag_i == a_q.tag)
    |=> (a_q.tag == '0 && a_q.val == $past(cdb_data_i)));

  p_capture_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && b_q.tag != '0 && cdb_valid_i && cdb_tag_i == b_q.tag)
    |=> (b_q.tag == '0 && b_q.val == $past(cdb_data_i)));

  p_hold_a_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && a_q.tag != '0 && !(cdb_valid_i && cdb_tag_i == a_q.tag))
    |=> $stable(a_q));

  p_bypass_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && a_i.tag != '0 && cdb_valid_i && cdb_tag_i == a_i.tag)
    |=> (a_q.tag == '0 && a_q.val == $past(cdb_data_i)));

  p_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && started_q && own_result && !alloc_i) |=> !busy_q);
endmodule

// File: rtl/rs_group.sv
module rs_group
  import rs_pkg::*;
#(
  parameter int unsigned N_STATIONS = 3,
  parameter int unsigned OP_W       = 4,
  parameter int unsigned DST_W      = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_valid_i,
  output logic                 issue_ready_o,
  input  logic [OP_W-1:0]      issue_op_i,
  input  logic [DST_W-1:0]     issue_dst_i,
  input  logic [RS_TAG_W-1:0]  issue_a_tag_i,
  input  logic [RS_DATA_W-1:0] issue_a_val_i,
  input  logic [RS_TAG_W-1:0]  issue_b_tag_i,
  input  logic [RS_DATA_W-1:0] issue_b_val_i,
  output logic [RS_TAG_W-1:0]  issue_tag_o,
  input  logic                 cdb_valid_i,
  input  logic [RS_TAG_W-1:0]  cdb_tag_i,
  input  logic [RS_DATA_W-1:0] cdb_data_i,
  output logic                 disp_valid_o,
  output logic [OP_W-1:0]      disp_op_o,
  output logic [DST_W-1:0]     disp_dst_o,
  output logic [RS_DATA_W-1:0] disp_a_o,
  output logic [RS_DATA_W-1:0] disp_b_o,
  output logic [RS_TAG_W-1:0]  disp_tag_o
);
  localparam int unsigned IDX_W = (N_STATIONS > 1) ? $clog2(N_STATIONS) : 1;

  initial begin
    if (N_STATIONS >= (1 << RS_TAG_W)) $error("station tags exceed tag space");
  end

  logic [N_STATIONS-1:0] busy_vec, ready_vec, alloc_vec, fire_vec, free_gnt;
  logic                  any_free, any_ready;
  logic [IDX_W-1:0]      free_idx, disp_idx;

  logic [OP_W-1:0]  st_op  [N_STATIONS];
  logic [DST_W-1:0] st_dst [N_STATIONS];
  data_t            st_a   [N_STATIONS];
  data_t            st_b   [N_STATIONS];

  operand_t in_a, in_b;
  assign in_a = '{tag: issue_a_tag_i, val: issue_a_val_i};
  assign in_b = '{tag: issue_b_tag_i, val: issue_b_val_i};

  rs_lowest_pick #(.N(N_STATIONS)) u_free_pick (
    .req_i (~busy_vec),
    .gnt_o (free_gnt),
    .any_o (any_free),
    .idx_o (free_idx)
  );

  rs_lowest_pick #(.N(N_STATIONS)) u_disp_pick (
    .req_i (ready_vec),
    .gnt_o (fire_vec),
    .any_o (any_ready),
    .idx_o (disp_idx)
  );

  assign issue_ready_o = any_free;
  assign issue_tag_o   = tag_t'(free_idx) + tag_t'(1);
  assign alloc_vec     = (issue_valid_i && any_free) ? free_gnt : '0;

  for (genvar i = 0; i < N_STATIONS; i++) begin : g_st
    rs_entry #(
      .OP_W   (OP_W),
      .DST_W  (DST_W),
      .MY_TAG (tag_t'(i + 1))
    ) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_vec[i]),
      .op_i        (issue_op_i),
      .dst_i       (issue_dst_i),
      .a_i         (in_a),
      .b_i         (in_b),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_data_i  (cdb_data_i),
      .fire_i      (fire_vec[i]),
      .busy_o      (busy_vec[i]),
      .ready_o     (ready_vec[i]),
      .op_o        (st_op[i]),
      .dst_o       (st_dst[i]),
      .a_o         (st_a[i]),
      .b_o         (st_b[i])
    );
  end

  assign disp_valid_o = any_ready;
  assign disp_op_o    = st_op[disp_idx];
  assign disp_dst_o   = st_dst[disp_idx];
  assign disp_a_o     = st_a[disp_idx];
  assign disp_b_o     = st_b[disp_idx];
  assign disp_tag_o   = tag_t'(disp_idx) + tag_t'(1);

  p_one_alloc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc_vec));

  p_stall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !issue_ready_o) |-> (alloc_vec == '0));

  p_one_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fire_vec));

  p_lowest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_vec != '0) |-> ((ready_vec & (fire_vec - 1'b1)) == '0));

  p_disp_tag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (disp_tag_o != '0 && disp_tag_o <= tag_t'(N_STATIONS)));
endmodule

// File: tb/rs_group_test.sv
module rs_group_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [3:0]  op;
    logic [4:0]  dst;
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [3:0]  issue_op = '0;
  logic [4:0]  issue_dst = '0;
  logic [3:0]  a_tag = '0, b_tag = '0;
  logic [63:0] a_val = '0, b_val = '0;
  logic [3:0]  issue_tag;
  logic        cdb_valid = 1'b0;
  logic [3:0]  cdb_tag = '0;
  logic [63:0] cdb_data = '0;
  logic        disp_valid;
  logic [3:0]  disp_op;
  logic [4:0]  disp_dst;
  logic [63:0] disp_a, disp_b;
  logic [3:0]  disp_tag;

  int checks = 0;
  int errors = 0;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_group uut (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
    .issue_op_i(issue_op), .issue_dst_i(issue_dst),
    .issue_a_tag_i(a_tag), .issue_a_val_i(a_val),
    .issue_b_tag_i(b_tag), .issue_b_val_i(b_val),
    .issue_tag_o(issue_tag),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
    .disp_valid_o(disp_valid), .disp_op_o(disp_op), .disp_dst_o(disp_dst),
    .disp_a_o(disp_a), .disp_b_o(disp_b), .disp_tag_o(disp_tag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every dispatch with the scoreboard head (R3 R9)
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected dispatch tag", 64'(disp_tag), 64'd0);
      end else begin
        item_t e;
        item_t got;
        e = exp_q.pop_front();
        got = '{op: disp_op, dst: disp_dst, a: disp_a, b: disp_b, tag: disp_tag};
        check(got.tag == e.tag, "R7", "dispatch tag", 64'(got.tag), 64'(e.tag));
        check(got.a == e.a, "R4", "operand a", got.a, e.a);
        check(got.b == e.b, "R2", "operand b", got.b, e.b);
        check(got.op == e.op && got.dst == e.dst, "R9", "op/dst",
              64'({got.op, got.dst}), 64'({e.op, e.dst}));
      end
    end
  end

  task automatic push(input logic [3:0] op, input logic [4:0] dst,
                      input logic [63:0] a, input logic [63:0] b, input logic [3:0] tag);
    exp_q.push_back('{op: op, dst: dst, a: a, b: b, tag: tag});
  endtask

  task automatic do_issue(input logic [3:0] op, input logic [4:0] dst,
                          input logic [3:0] ta, input logic [63:0] va,
                          input logic [3:0] tb, input logic [63:0] vb,
                          output logic [3:0] tag);
    @(negedge clk);
    issue_valid = 1'b1; issue_op = op; issue_dst = dst;
    a_tag = ta; a_val = va; b_tag = tb; b_val = vb;
    while (!issue_ready) @(negedge clk);
    tag = issue_tag;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic broadcast(input logic [3:0] tag, input logic [63:0] data);
    @(negedge clk);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_data = data;
    @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, req, "dispatches outstanding", 64'(exp_q.size()), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] t;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(issue_ready === 1'b1, "R8", "issue_ready after reset", 64'(issue_ready), 64'd1);
    check(disp_valid === 1'b0, "R8", "disp_valid in reset", 64'(disp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(disp_valid === 1'b0, "R8", "disp_valid after reset", 64'(disp_valid), 64'd0);

    // R2 both operands valid at issue
    push(4'd3, 5'd7, 64'd10, 64'd20, 4'd1);
    do_issue(4'd3, 5'd7, 4'd0, 64'd10, 4'd0, 64'd20, t);
    check(t == 4'd1, "R1", "first station tag", 64'(t), 64'd1);
    drain("R2");
    check(disp_valid == 1'b0, "R3", "no second dispatch", 64'(disp_valid), 64'd0);
    broadcast(4'd1, 64'hAAAA);

    // fill all stations waiting on tag 9
    do_issue(4'd1, 5'd1, 4'd9, 64'd0, 4'd0, 64'h11, t);
    check(t == 4'd1, "R1", "fill tag 1", 64'(t), 64'd1);
    do_issue(4'd2, 5'd2, 4'd9, 64'd0, 4'd0, 64'h22, t);
    check(t == 4'd2, "R1", "fill tag 2", 64'(t), 64'd2);
    do_issue(4'd4, 5'd3, 4'd9, 64'd0, 4'd0, 64'h33, t);
    check(t == 4'd3, "R1", "fill tag 3", 64'(t), 64'd3);
    check(issue_ready == 1'b0, "R1", "ready low when full", 64'(issue_ready), 64'd0);
    // stalled issue attempt must not overwrite a station
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 4'hF; issue_dst = 5'h1F;
    a_tag = 4'd0; a_val = 64'hDEAD; b_tag = 4'd0; b_val = 64'hBEEF;
    repeat (3) @(negedge clk);
    issue_valid = 1'b0;
    check(disp_valid == 1'b0, "R3", "waiting stations held", 64'(disp_valid), 64'd0);
    // R10 nonmatching tag
    broadcast(4'd10, 64'h5050);
    @(negedge clk);
    check(disp_valid == 1'b0, "R10", "no wake on other tag", 64'(disp_valid), 64'd0);
    // R4 one broadcast wakes all, R7 lowest first
    push(4'd1, 5'd1, 64'h99, 64'h11, 4'd1);
    push(4'd2, 5'd2, 64'h99, 64'h22, 4'd2);
    push(4'd4, 5'd3, 64'h99, 64'h33, 4'd3);
    broadcast(4'd9, 64'h99);
    check(disp_valid && disp_tag == 4'd1, "R7", "first in order", 64'(disp_tag), 64'd1);
    @(negedge clk);
    check(disp_valid && disp_tag == 4'd2, "R7", "second in order", 64'(disp_tag), 64'd2);
    @(negedge clk);
    check(disp_valid && disp_tag == 4'd3, "R7", "third in order", 64'(disp_tag), 64'd3);
    drain("R4");

    // R6 free on own tag
    check(issue_ready == 1'b0, "R6", "still full before free", 64'(issue_ready), 64'd0);
    broadcast(4'd2, 64'h1);
    check(issue_ready == 1'b1, "R6", "ready after free", 64'(issue_ready), 64'd1);
    check(issue_tag == 4'd2, "R1", "freed station offered", 64'(issue_tag), 64'd2);
    do_issue(4'd5, 5'd5, 4'd12, 64'd0, 4'd13, 64'd0, t);
    check(t == 4'd2, "R1", "reuse station 2", 64'(t), 64'd2);
    broadcast(4'd1, 64'h1);
    broadcast(4'd3, 64'h1);
    do_issue(4'd6, 5'd6, 4'd13, 64'd0, 4'd0, 64'h66, t);
    check(t == 4'd1, "R1", "lowest free is 1", 64'(t), 64'd1);
    // tag 13 feeds both stations; only station 1 becomes complete
    push(4'd6, 5'd6, 64'h1313, 64'h66, 4'd1);
    broadcast(4'd13, 64'h1313);
    drain("R4");
    push(4'd5, 5'd5, 64'h1212, 64'h1313, 4'd2);
    broadcast(4'd12, 64'h1212);
    drain("R4");
    broadcast(4'd1, 64'h1);
    broadcast(4'd2, 64'h1);

    // R5 bypass at issue
    push(4'd7, 5'd9, 64'h1414, 64'h77, 4'd1);
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 4'd7; issue_dst = 5'd9;
    a_tag = 4'd14; a_val = 64'd0; b_tag = 4'd0; b_val = 64'h77;
    cdb_valid = 1'b1; cdb_tag = 4'd14; cdb_data = 64'h1414;
    check(issue_ready == 1'b1, "R5", "ready for bypass", 64'(issue_ready), 64'd1);
    @(negedge clk);
    issue_valid = 1'b0; cdb_valid = 1'b0;
    check(disp_valid && disp_a == 64'h1414, "R5", "bypass operand", disp_a, 64'h1414);
    drain("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule